// File: doc/BRIEF.md
# 4:2 Compressor Tree Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. The multiplier operand is split into two nibbles. Each nibble gates the multiplicand into four shifted rows of AND terms. One bank of eight 4:2 compressors folds each set of four rows into a sum row and a carry row. A bank of eleven 4:2 compressors then merges those four rows into two summands. A 16-bit carry-propagate adder produces the product.

The 4:2 cell adds four data bits and a carry-in. It returns a sum, a carry and a carry-out. The carry-out is formed only from the first three data bits, so it never waits on the carry-in. Inside each bank, the carry-out of one column feeds the carry-in of the next column up. Any column position with no partial product is fed a constant zero. Two parameters choose whether the operands are registered on the way in and whether the product is registered on the way out. The block is otherwise purely combinational.

Top module: `cmp42_mult8`

## Requirements
- R1: For every pair of operands a and b, p equals the unsigned product a*b, as a 16-bit value.
- R2: The latency is IN_REG plus OUT_REG clock cycles. With the defaults (both 1), operands applied before a rising edge appear on p after the second rising edge. Until then, p shows the previous result.
- R3: While rst_n is low, every enabled register is cleared asynchronously. If IN_REG or OUT_REG is set, p reads 0 during reset whatever the operands are.
- R4: If either operand is zero, p is zero.
- R5: The largest operands, a=255 and b=255, give p=16'hFE01. This carry reaches bit 15 through the final adder.
- R6: If the low nibble of the multiplier is zero, the lower group's rows are all zero, and p equals a*b[7:4] shifted left by four. Bits p[3:0] are then zero.
- R7: If the multiplier is a power of two 2^k, p equals a shifted left by k.
- R8: Each 4:2 cell satisfies sum + 2*(carry + carry-out) = the number of ones among its five inputs. Each group's sum and carry rows add up to the multiplicand times that group's nibble. The two merged summands add up to the full product. This also holds when every input of a column is one (a=255 with a nibble of 4'hF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional operand and product registers |
| rst_n | input | 1 | Asynchronous active-low reset for those registers |
| a | input | 8 | Multiplicand |
| b | input | 8 | Multiplier; bits 3..0 drive the lower group and bits 7..4 drive the upper group |
| p | output | 16 | Product a*b |

## Verification
The hardest case to reach from the ports is a carry chain that ripples through a whole compressor bank while every column is saturated, with several carry-outs landing in one column. Only a few operand pairs put four ones into every column of a group while also loading the merge bank's top columns. An exhaustive pipelined sweep of all 65536 operand pairs reaches those pairs without having to pick them out. Each result is tagged by the property its operands exercise: a zero operand, the largest operands, an empty low nibble, a power-of-two multiplier or a saturated group.

// File: rtl/cmp42_mult8.sv
module cmp42_mult8 #(
  parameter int IN_REG  = 1,
  parameter int OUT_REG = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  a,
  input  logic [7:0]  b,
  output logic [15:0] p
);
  localparam int W   = 8;
  localparam int PW  = 2 * W;
  localparam int GR  = 4;
  localparam int GW  = W + 3;
  localparam int GLO = 2;
  localparam int GHI = W + 1;
  localparam int MLO = GR;
  localparam int MHI = GW + GR - 1;

  function automatic logic [1:0] c42_sc(input logic [3:0] x, input logic ci);
    logic t;
    t = ^x[2:0];
    return {(t & x[3]) | (t & ci) | (x[3] & ci), t ^ x[3] ^ ci};
  endfunction

  function automatic logic c42_co(input logic [2:0] x);
    return (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
  endfunction

  logic [W-1:0] a_q, b_q;

  if (IN_REG != 0) begin : g_inreg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        a_q <= a;
        b_q <= b;
      end
  end else begin : g_inwire
    assign a_q = a;
    assign b_q = b;
  end

  logic [W-1:0] pp [W];
  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = a_q & {W{b_q[i]}};
  end

  logic [GW-1:0]    sr   [2];
  logic [GW-1:0]    cr   [2];
  logic [GHI:GLO]   gsum [2];
  logic [GHI:GLO]   gcar [2];
  logic [GHI-1:GLO] gco  [2];

  for (genvar g = 0; g < 2; g++) begin : g_grp
    for (genvar c = GLO; c <= GHI; c++) begin : g_col
      logic [3:0] x;
      logic       ci;
      for (genvar k = 0; k < GR; k++) begin : g_in
        if (c - k >= 0 && c - k < W) begin : g_bit
          assign x[k] = pp[GR*g+k][c-k];
        end else begin : g_zero
          assign x[k] = 1'b0;
        end
      end
      if (c == GLO) begin : g_ci0
        assign ci = 1'b0;
      end else begin : g_cin
        assign ci = gco[g][c-1];
      end
      assign {gcar[g][c], gsum[g][c]} = c42_sc(x, ci);
      if (c < GHI) begin : g_co
        assign gco[g][c] = c42_co(x[2:0]);
      end
    end
    assign sr[g] = {pp[GR*g+3][W-1], gsum[g], pp[GR*g][1], pp[GR*g][0]};
    assign cr[g] = {gcar[g], 1'b0, pp[GR*g+1][0], 1'b0};
  end

  logic [MHI:MLO]   msum, mcar;
  logic [MHI-1:MLO] mco;

  for (genvar c = MLO; c <= MHI; c++) begin : g_mrg
    logic [3:0] x;
    logic       ci;
    if (c < GW) begin : g_lo
      assign x[0] = sr[0][c];
      assign x[1] = cr[0][c];
    end else begin : g_lz
      assign x[0] = 1'b0;
      assign x[1] = 1'b0;
    end
    assign x[2] = sr[1][c-GR];
    assign x[3] = cr[1][c-GR];
    if (c == MLO) begin : g_ci0
      assign ci = 1'b0;
    end else begin : g_cin
      assign ci = mco[c-1];
    end
    assign {mcar[c], msum[c]} = c42_sc(x, ci);
    if (c < MHI) begin : g_co
      assign mco[c] = c42_co(x[2:0]);
    end
  end

  logic [PW-1:0] s2, c2, prod;
  assign s2   = {1'b0, msum, sr[0][GR-1:0]};
  assign c2   = {mcar, 1'b0, cr[0][GR-1:0]};
  assign prod = s2 + c2;

  if (OUT_REG != 0) begin : g_outreg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) p <= '0;
      else        p <= prod;
  end else begin : g_outwire
    assign p = prod;
  end
endmodule

// File: rtl/cmp42_mult8_chk.sv
module cmp42_mult8_chk #(
  parameter int IN_REG  = 1,
  parameter int OUT_REG = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  a,
  input logic [7:0]  b,
  input logic [15:0] p,
  input logic [7:0]  a_q,
  input logic [7:0]  b_q,
  input logic [10:0] sa,
  input logic [10:0] ca,
  input logic [10:0] sb,
  input logic [10:0] cb,
  input logic [15:0] s2,
  input logic [15:0] c2
);
  localparam int LAT = IN_REG + OUT_REG;

  logic [15:0] expq [0:LAT];
  assign expq[0] = {8'b0, a} * {8'b0, b};
  for (genvar i = 1; i <= LAT; i++) begin : g_exp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) expq[i] <= '0;
      else        expq[i] <= expq[i-1];
  end

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    p == expq[LAT]);

  if (LAT > 0) begin : g_rst
    a_r3_reset_zero: assert property (@(posedge clk) !rst_n |-> p == 16'd0);
  end

  a_r8_group_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ({5'b0, sa} + {5'b0, ca}) == ({8'b0, a_q} * {12'b0, b_q[3:0]}));

  a_r8_group_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ({5'b0, sb} + {5'b0, cb}) == ({8'b0, a_q} * {12'b0, b_q[7:4]}));

  a_r8_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 + c2) == ({8'b0, a_q} * {8'b0, b_q}));

  a_r6_low_group_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q[3:0] == 4'd0) |-> (sa == 11'd0 && ca == 11'd0));
endmodule

bind cmp42_mult8 cmp42_mult8_chk #(.IN_REG(IN_REG), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p),
  .a_q(a_q), .b_q(b_q),
  .sa(sr[0]), .ca(cr[0]), .sb(sr[1]), .cb(cr[1]),
  .s2(s2), .c2(c2)
);

// File: tb/cmp42_mult8_tb.sv
module cmp42_mult8_tb_top;
  localparam int IN_REG  = 1;
  localparam int OUT_REG = 1;
  localparam int LAT     = IN_REG + OUT_REG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = 8'hA5;
  logic [7:0]  b = 8'h3C;
  logic [15:0] p;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cmp42_mult8 #(.IN_REG(IN_REG), .OUT_REG(OUT_REG)) dut_i (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] x, input logic [7:0] y);
    if (x == 0 || y == 0)                         return "R4 zero operand";
    if (x == 8'hFF && y == 8'hFF)                 return "R5 max operands";
    if (x == 8'hFF && (y[3:0] == 4'hF || y[7:4] == 4'hF)) return "R8 saturated group";
    if ((y & (y - 8'd1)) == 0)                    return "R7 power of two";
    if (y[3:0] == 0)                              return "R6 empty low nibble";
    return "R1 product";
  endfunction

  initial begin
    logic [15:0] q[$];
    logic [15:0] e;
    repeat (3) @(negedge clk);
    // R3: p cleared while reset is held, operands nonzero
    if (LAT > 0) chk("R3 reset clears p", p, 16'd0);
    else         chk("R3 reset clears p", p, 16'hA5 * 16'h3C);
    @(negedge clk);
    chk("R3 reset state held", p, (LAT > 0) ? 16'd0 : 16'(16'hA5 * 16'h3C));
    a = 8'd0;
    b = 8'd0;
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    // R2: latency of a single operand change
    for (int k = 0; k <= LAT; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) begin
        a = 8'h37;
        b = 8'h5B;
      end
      #1;
      chk("R2 latency", p, (k < LAT) ? 16'd0 : 16'(16'h37 * 16'h5B));
    end
    // R1/R4-R8: exhaustive pipelined sweep
    for (int n = 0; n < 65536 + LAT; n++) begin
      @(negedge clk);
      a = n[15:8];
      b = n[7:0];
      q.push_back({8'b0, a} * {8'b0, b});
      #1;
      if (q.size() == LAT + 1) begin
        e = q.pop_front();
        if (n - LAT < 65536)
          chk(tag_of(8'((n - LAT) >> 8), 8'(n - LAT)), p, e);
      end
    end
    // R5 and R7 directed after the sweep
    @(negedge clk);
    a = 8'hFF;
    b = 8'hFF;
    repeat (LAT) @(negedge clk);
    #1;
    chk("R5 max operands", p, 16'hFE01);
    @(negedge clk);
    a = 8'hC3;
    b = 8'h80;
    repeat (LAT) @(negedge clk);
    #1;
    chk("R7 power of two shift", p, 16'(8'hC3) << 7);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule